// File: doc/BRIEF.md
# Multi-Bank DRAM Command Sequencer

This block sits between a simple request front end and a DRAM device that is modelled as a small set of independent banks. It takes one read or write request at a time over a valid/ready handshake. It splits the request address into row, bank and column fields. It then emits the activate, column and precharge commands the device needs, one per clock, on a shared command/address bus.

Each bank keeps its own row open after an access. A later request to the same row goes straight to a column command. A request to a different row first closes the open one. Every bank runs its own minimum-time counters, so a bank can be activated while another bank is still inside its own timing windows.

A free-running interval timer schedules refresh. Pending refresh blocks new requests. The open banks are closed and a refresh command is issued. The bus then stays quiet for the refresh recovery time. Reads produce a response pulse, tagged with the request identifier, a fixed number of cycles after the read command.

Top module: `dram_cmd_seq`

## Requirements
- R1: The request address is split as column = addr[COL_W-1:0], bank = addr[COL_W+BANK_W-1:COL_W], row = the upper ROW_W bits. An activate puts the row on cmd_addr_o, a read or write puts the column there, a precharge drives zero, and cmd_bank_o always carries the target bank.
- R2: A request to a closed bank issues an activate in the first cycle after acceptance in which T_RP cycles have passed since that bank's last precharge, and its column command follows exactly T_RCD cycles after the activate.
- R3: A request to the row already open in its bank issues only a column command, in the first cycle after acceptance at least T_RCD cycles after that row's activate, with no activate or precharge.
- R4: A request to a different row of an open bank issues a precharge in the first cycle after acceptance at least T_RAS cycles after that bank's activate, an activate exactly T_RP cycles later, and the column command exactly T_RCD cycles after that.
- R5: cmd_o carries at most one command per clock, encoded as 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, and no command appears other than those a request or a refresh calls for.
- R6: A refresh command appears at least once in every window of T_REFI + 2*(T_RAS+T_RP+T_RCD) + NUM_BANKS + 4 cycles, counted from reset and from each previous refresh.
- R7: Before a refresh command every bank is closed, with each of its precharges at least T_RAS after that bank's activate and the refresh at least T_RP after every precharge. After refresh all banks are closed, so the next request activates.
- R8: In the T_RFC-1 cycles that follow a refresh command no command is issued and req_ready_o is low.
- R9: Each read command is followed exactly CL cycles later by a one-cycle resp_valid_o pulse carrying that request's id. Writes and all other cycles give no pulse.
- R10: A request is taken at a clock edge where req_valid_i and req_ready_o are both high. Requests are served one at a time in arrival order, and req_ready_o stays low while a request is held or a refresh is pending or running.
- R11: An activate to a closed bank is not delayed by timing windows still open in other banks.
- R12: After reset cmd_o is 0, resp_valid_o is low, req_ready_o is high and every bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ROW_W+BANK_W+COL_W | Request address {row, bank, column} |
| req_id_i | input | ID_W | Request tag returned with read data |
| cmd_o | output | 3 | Command code |
| cmd_bank_o | output | BANK_W | Command target bank |
| cmd_addr_o | output | max(ROW_W,COL_W) | Multiplexed row or column address |
| resp_valid_o | output | 1 | Read response strobe |
| resp_id_o | output | ID_W | Tag of the read being answered |

## Verification
The bench predicts the exact cycle, bank and address of every command from its own per-bank record of open rows and activate and precharge times. It goes after row hits, which a design that always reactivates would answer late with a stray activate. It also drives misses issued right after an activate, where a design ignoring the activate-to-precharge minimum would precharge too early. Requests to a second bank while the first is still in its windows catch a design that serializes banks. Refresh is checked for closed banks, a quiet recovery window and bounded spacing, so a dropped refresh or one issued over an open row is reported. Read pulses are matched in cycle and tag, so a latency off by one is reported.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_PRECH  = 2'd2
    } bank_st_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dseq_bank.sv
module dseq_bank
    import dseq_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             col_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             is_open_o,
    output logic [ROW_W-1:0] open_row_o,
    output logic             can_act_o,
    output logic             can_pre_o,
    output logic             can_col_o
);
    localparam int TMAX  = max3(T_RCD, T_RAS, T_RP);
    localparam int CNT_W = $clog2(TMAX + 1);

    bank_st_e         state_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] rcd_q, ras_q, rp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BK_IDLE;
            row_q   <= '0;
            rcd_q   <= '0;
            ras_q   <= '0;
            rp_q    <= '0;
        end else begin
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (ras_q != '0) ras_q <= ras_q - 1'b1;
            if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
            if (act_i) begin
                state_q <= BK_ACTIVE;
                row_q   <= row_i;
                rcd_q   <= CNT_W'(T_RCD - 1);
                ras_q   <= CNT_W'(T_RAS - 1);
            end else if (pre_i) begin
                state_q <= BK_PRECH;
                rp_q    <= CNT_W'(T_RP - 1);
            end else if (state_q == BK_PRECH && rp_q == '0) begin
                state_q <= BK_IDLE;
            end
        end
    end

    assign is_open_o  = (state_q == BK_ACTIVE);
    assign open_row_o = row_q;
    assign can_act_o  = (state_q == BK_IDLE) || (state_q == BK_PRECH && rp_q == '0);
    assign can_pre_o  = (state_q == BK_ACTIVE) && (ras_q == '0);
    assign can_col_o  = (state_q == BK_ACTIVE) && (rcd_q == '0);

    // R2: activate only into a closed bank whose precharge time has run out
    assert_act_closed_R2: assert property (@(posedge clk) disable iff (rst)
        act_i |-> (state_q != BK_ACTIVE && rp_q == '0));

    // R4: precharge only after the activate-to-precharge minimum
    assert_pre_after_ras_R4: assert property (@(posedge clk) disable iff (rst)
        pre_i |-> (state_q == BK_ACTIVE && ras_q == '0));

    // R3: column access only into an open row after activate-to-column time
    assert_col_after_rcd_R3: assert property (@(posedge clk) disable iff (rst)
        col_i |-> (state_q == BK_ACTIVE && rcd_q == '0));

    // R5: one operation per bank per clock
    assert_one_op_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_i, pre_i, col_i}));

    // R2: an activate leaves the bank open with the requested row
    assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
        act_i |=> (state_q == BK_ACTIVE && row_q == $past(row_i)));

endmodule

// File: rtl/dseq_refresh.sv
module dseq_refresh #(
    parameter int T_REFI = 250,
    parameter int T_RFC  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_issue_i,
    output logic pending_o,
    output logic busy_o
);
    localparam int IW = (T_REFI <= 2) ? 1 : $clog2(T_REFI);
    localparam int RW = $clog2(T_RFC + 1);

    logic [IW-1:0] intv_q;
    logic [RW-1:0] rfc_q;
    logic          pending_q, busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            intv_q    <= '0;
            rfc_q     <= '0;
            pending_q <= 1'b0;
            busy_q    <= 1'b0;
        end else begin
            if (rfc_q != '0) rfc_q <= rfc_q - 1'b1;
            if (busy_q && rfc_q == '0) busy_q <= 1'b0;
            if (ref_issue_i) begin
                pending_q <= 1'b0;
                busy_q    <= 1'b1;
                rfc_q     <= RW'(T_RFC - 1);
            end
            if (intv_q == IW'(T_REFI - 1)) begin
                intv_q    <= '0;
                pending_q <= 1'b1;
            end else begin
                intv_q <= intv_q + 1'b1;
            end
        end
    end

    assign pending_o = pending_q;
    assign busy_o    = busy_q;

    // R6: a refresh command is only issued against a pending request for one
    assert_ref_pending_R6: assert property (@(posedge clk) disable iff (rst)
        ref_issue_i |-> pending_q);

    // R8: no second refresh while the recovery window runs
    assert_no_ref_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !ref_issue_i);

endmodule

// File: rtl/dseq_rdpipe.sv
module dseq_rdpipe #(
    parameter int CL   = 4,
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_i,
    input  logic [ID_W-1:0] id_i,
    output logic            valid_o,
    output logic [ID_W-1:0] id_o
);
    logic            v_q  [CL];
    logic [ID_W-1:0] id_q [CL];

    for (genvar k = 0; k < CL; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) v_q[k] <= 1'b0;
                else     v_q[k] <= rd_i;
                id_q[k] <= id_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) v_q[k] <= 1'b0;
                else     v_q[k] <= v_q[k-1];
                id_q[k] <= id_q[k-1];
            end
        end
    end

    assign valid_o = v_q[CL-1];
    assign id_o    = id_q[CL-1];

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
    import dseq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 10,
    parameter int COL_W     = 6,
    parameter int ID_W      = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RFC     = 10,
    parameter int T_REFI    = 250,
    parameter int CL        = 4,
    localparam int BANK_W   = width_of(NUM_BANKS),
    localparam int ADDR_W   = ROW_W + BANK_W + COL_W,
    localparam int CA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [ID_W-1:0]   req_id_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [CA_W-1:0]   cmd_addr_o,
    output logic              resp_valid_o,
    output logic [ID_W-1:0]   resp_id_o
);
    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [ID_W-1:0]   id;
    } req_t;

    req_t held_q;
    logic held_v_q;

    logic [NUM_BANKS-1:0] act_vec, pre_vec, col_vec;
    logic [NUM_BANKS-1:0] is_open, can_act, can_pre, can_col;
    logic [ROW_W-1:0]     open_row [NUM_BANKS];
    logic ref_pending, ref_busy, ref_issue, done;

    cmd_e              sel_cmd;
    logic [BANK_W-1:0] sel_bank;
    logic [CA_W-1:0]   sel_addr;

    cmd_e            cmd_q;
    logic [BANK_W-1:0] bank_q;
    logic [CA_W-1:0] addr_q;
    logic [ID_W-1:0] cmd_id_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        dseq_bank #(
            .ROW_W (ROW_W),
            .T_RCD (T_RCD),
            .T_RAS (T_RAS),
            .T_RP  (T_RP)
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .act_i      (act_vec[g]),
            .pre_i      (pre_vec[g]),
            .col_i      (col_vec[g]),
            .row_i      (held_q.row),
            .is_open_o  (is_open[g]),
            .open_row_o (open_row[g]),
            .can_act_o  (can_act[g]),
            .can_pre_o  (can_pre[g]),
            .can_col_o  (can_col[g])
        );
    end

    dseq_refresh #(
        .T_REFI (T_REFI),
        .T_RFC  (T_RFC)
    ) u_refresh (
        .clk         (clk),
        .rst         (rst),
        .ref_issue_i (ref_issue),
        .pending_o   (ref_pending),
        .busy_o      (ref_busy)
    );

    assign req_ready_o = !held_v_q && !ref_pending && !ref_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v_q <= 1'b0;
            held_q   <= '0;
        end else if (req_valid_i && req_ready_o) begin
            held_v_q     <= 1'b1;
            held_q.wr    <= req_write_i;
            held_q.col   <= req_addr_i[COL_W-1:0];
            held_q.bank  <= req_addr_i[COL_W +: BANK_W];
            held_q.row   <= req_addr_i[ADDR_W-1 -: ROW_W];
            held_q.id    <= req_id_i;
        end else if (done) begin
            held_v_q <= 1'b0;
        end
    end

    // One command per clock: the held request first, refresh only when idle.
    always_comb begin
        logic found;
        sel_cmd   = CMD_NOP;
        sel_bank  = '0;
        sel_addr  = '0;
        act_vec   = '0;
        pre_vec   = '0;
        col_vec   = '0;
        ref_issue = 1'b0;
        done      = 1'b0;
        found     = 1'b0;
        if (held_v_q) begin
            sel_bank = held_q.bank;
            if (is_open[held_q.bank] && open_row[held_q.bank] == held_q.row) begin
                if (can_col[held_q.bank]) begin
                    sel_cmd               = held_q.wr ? CMD_WR : CMD_RD;
                    sel_addr              = CA_W'(held_q.col);
                    col_vec[held_q.bank]  = 1'b1;
                    done                  = 1'b1;
                end
            end else if (is_open[held_q.bank]) begin
                if (can_pre[held_q.bank]) begin
                    sel_cmd              = CMD_PRE;
                    pre_vec[held_q.bank] = 1'b1;
                end
            end else if (can_act[held_q.bank]) begin
                sel_cmd              = CMD_ACT;
                sel_addr             = CA_W'(held_q.row);
                act_vec[held_q.bank] = 1'b1;
            end
        end else if (ref_pending) begin
            if (|is_open) begin
                for (int i = 0; i < NUM_BANKS; i++) begin
                    if (!found && is_open[i] && can_pre[i]) begin
                        found      = 1'b1;
                        sel_cmd    = CMD_PRE;
                        sel_bank   = BANK_W'(i);
                        pre_vec[i] = 1'b1;
                    end
                end
            end else if (&can_act) begin
                sel_cmd   = CMD_REF;
                ref_issue = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_NOP;
            bank_q   <= '0;
            addr_q   <= '0;
            cmd_id_q <= '0;
        end else begin
            cmd_q    <= sel_cmd;
            bank_q   <= sel_bank;
            addr_q   <= sel_addr;
            cmd_id_q <= held_q.id;
        end
    end

    assign cmd_o      = cmd_q;
    assign cmd_bank_o = bank_q;
    assign cmd_addr_o = addr_q;

    dseq_rdpipe #(
        .CL   (CL),
        .ID_W (ID_W)
    ) u_rdpipe (
        .clk     (clk),
        .rst     (rst),
        .rd_i    (cmd_q == CMD_RD),
        .id_i    (cmd_id_q),
        .valid_o (resp_valid_o),
        .id_o    (resp_id_o)
    );

    // R5: across all banks and refresh, at most one operation per clock
    assert_single_cmd_R5: assert property (@(posedge clk) disable iff (rst)
        $countones({act_vec, pre_vec, col_vec, ref_issue}) <= 1);

    // R8: the scheduler stays silent during refresh recovery
    assert_quiet_recovery_R8: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> (sel_cmd == CMD_NOP));

    // R7: refresh only with every bank closed
    assert_ref_all_closed_R7: assert property (@(posedge clk) disable iff (rst)
        ref_issue |-> (is_open == '0));

    // R10: an accepted request blocks the next one for at least a cycle
    assert_one_at_a_time_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: tb/dram_cmd_seq_tb.sv
module dram_cmd_seq_tb;
    localparam int NB     = 4;
    localparam int ROW_W  = 10;
    localparam int COL_W  = 6;
    localparam int ID_W   = 4;
    localparam int T_RCD  = 3;
    localparam int T_RP   = 3;
    localparam int T_RAS  = 6;
    localparam int T_RFC  = 10;
    localparam int T_REFI = 250;
    localparam int CL     = 4;
    localparam int BANK_W = 2;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int CA_W   = ROW_W;
    localparam int REF_BOUND = T_REFI + 2 * (T_RAS + T_RP + T_RCD) + NB + 4;
    localparam int WATCHDOG  = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [ID_W-1:0]   req_id    = '0;
    logic              req_ready;
    logic [2:0]        cmd;
    logic [BANK_W-1:0] cmd_bank;
    logic [CA_W-1:0]   cmd_addr;
    logic              resp_valid;
    logic [ID_W-1:0]   resp_id;

    always #10 clk = ~clk;

    dram_cmd_seq #(
        .NUM_BANKS (NB), .ROW_W (ROW_W), .COL_W (COL_W), .ID_W (ID_W),
        .T_RCD (T_RCD), .T_RP (T_RP), .T_RAS (T_RAS), .T_RFC (T_RFC),
        .T_REFI (T_REFI), .CL (CL)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_id_i     (req_id),
        .cmd_o        (cmd),
        .cmd_bank_o   (cmd_bank),
        .cmd_addr_o   (cmd_addr),
        .resp_valid_o (resp_valid),
        .resp_id_o    (resp_id)
    );

    typedef struct {
        int    t;
        int    code;
        int    bank;
        int    addr;
        string tag;
    } exp_cmd_t;

    typedef struct {
        int t;
        int id;
    } exp_rsp_t;

    exp_cmd_t eq[$];
    exp_rsp_t rq[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_t = -1;
    int last_ref = 0;
    int ref_count = 0;
    bit finished = 1'b0;

    bit mdl_open [NB];
    int mdl_row  [NB];
    int mdl_act  [NB];
    int mdl_pre  [NB];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Predict the command sequence for a request taken at edge acc.
    task automatic predict(input int acc, input bit wr, input int b, input int r,
                           input int c, input int id);
        int base, t_pre, t_act, t_col;
        bit others_open;
        base = acc + 1;
        others_open = 1'b0;
        for (int i = 0; i < NB; i++) if (i != b && mdl_open[i]) others_open = 1'b1;
        if (mdl_open[b] && mdl_row[b] == r) begin
            t_col = imax(base, mdl_act[b] + T_RCD);
            eq.push_back('{t_col, wr ? 3 : 2, b, c, "R3"});
        end else if (mdl_open[b]) begin
            t_pre = imax(base, mdl_act[b] + T_RAS);
            t_act = t_pre + T_RP;
            t_col = t_act + T_RCD;
            eq.push_back('{t_pre, 4, b, 0, "R4"});
            eq.push_back('{t_act, 1, b, r, "R4"});
            eq.push_back('{t_col, wr ? 3 : 2, b, c, "R1"});
        end else begin
            t_act = imax(base, mdl_pre[b] + T_RP);
            t_col = t_act + T_RCD;
            eq.push_back('{t_act, 1, b, r, others_open ? "R11" : "R2"});
            eq.push_back('{t_col, wr ? 3 : 2, b, c, "R2"});
        end
        if (!wr) rq.push_back('{t_col + CL, id});
    endtask

    always @(negedge clk) begin
        int c, bk, ad;
        bit ok;
        if (rst) begin
            cyc = 0;
        end else if (!finished) begin
            cyc++;
            c  = int'(cmd);
            bk = int'(cmd_bank);
            ad = int'(cmd_addr);

            if (ref_t >= 0 && cyc > ref_t && cyc < ref_t + T_RFC) begin
                chk(c == 0, "R8", "command during refresh recovery", c, 0);
                chk(req_ready == 1'b0, "R8", "ready during refresh recovery", int'(req_ready), 0);
            end

            if (c != 0) begin
                if (eq.size() > 0) begin
                    exp_cmd_t e;
                    e = eq.pop_front();
                    checks++;
                    if (!(e.t == cyc && e.code == c && e.bank == bk && e.addr == ad)) begin
                        errors++;
                        $display("FAIL %s command: actual cmd=%0d bank=%0d addr=%0d t=%0d expected cmd=%0d bank=%0d addr=%0d t=%0d",
                                 e.tag, c, bk, ad, cyc, e.code, e.bank, e.addr, e.t);
                    end
                end else if (c == 4) begin
                    chk(mdl_open[bk] && (cyc - mdl_act[bk] >= T_RAS), "R7",
                        "refresh precharge timing", cyc - mdl_act[bk], T_RAS);
                end else if (c == 5) begin
                    ok = 1'b1;
                    for (int i = 0; i < NB; i++)
                        if (mdl_open[i] || (cyc - mdl_pre[i] < T_RP)) ok = 1'b0;
                    chk(ok, "R7", "refresh with bank open or precharging", int'(ok), 1);
                    chk(cyc - last_ref <= REF_BOUND, "R6", "refresh spacing",
                        cyc - last_ref, REF_BOUND);
                    last_ref = cyc;
                    ref_t = cyc;
                    ref_count++;
                end else begin
                    chk(1'b0, "R5", "unexpected command", c, 0);
                end
                if (c == 1) begin
                    mdl_open[bk] = 1'b1;
                    mdl_row[bk]  = ad;
                    mdl_act[bk]  = cyc;
                end else if (c == 4) begin
                    mdl_open[bk] = 1'b0;
                    mdl_pre[bk]  = cyc;
                end
            end else if (eq.size() > 0 && eq[0].t <= cyc) begin
                exp_cmd_t e;
                e = eq.pop_front();
                checks++;
                errors++;
                $display("FAIL %s missing command: actual cmd=0 t=%0d expected cmd=%0d t=%0d",
                         e.tag, cyc, e.code, e.t);
            end

            if (rq.size() > 0 && rq[0].t == cyc) begin
                exp_rsp_t x;
                x = rq.pop_front();
                chk(resp_valid == 1'b1, "R9", "read response strobe", int'(resp_valid), 1);
                chk(int'(resp_id) == x.id, "R9", "read response id", int'(resp_id), x.id);
            end else if (resp_valid) begin
                chk(1'b0, "R9", "unexpected read response", 1, 0);
            end

            if (req_valid && req_ready) begin
                predict(cyc + 1, req_write,
                        int'(req_addr[COL_W +: BANK_W]),
                        int'(req_addr[ADDR_W-1 -: ROW_W]),
                        int'(req_addr[COL_W-1:0]),
                        int'(req_id));
            end

            if (cyc - last_ref > REF_BOUND) begin
                chk(1'b0, "R6", "refresh overdue", cyc - last_ref, REF_BOUND);
                last_ref = cyc;
            end

            if (cyc > WATCHDOG) begin
                chk(1'b0, "R10", "watchdog expired", cyc, WATCHDOG);
                finish_run();
            end
        end
    end

    task automatic send(input bit wr, input int b, input int r, input int c, input int id);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {ROW_W'(r), BANK_W'(b), COL_W'(c)};
        req_id    = ID_W'(id);
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        bit [31:0] s;
        for (int i = 0; i < NB; i++) begin
            mdl_open[i] = 1'b0;
            mdl_row[i]  = 0;
            mdl_act[i]  = -1000;
            mdl_pre[i]  = -1000;
        end
        repeat (5) @(posedge clk);
        #2;
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state at the ports
        chk(req_ready == 1'b1, "R12", "ready after reset", int'(req_ready), 1);
        chk(cmd == 3'd0, "R12", "command after reset", int'(cmd), 0);
        chk(resp_valid == 1'b0, "R12", "response after reset", int'(resp_valid), 0);
        @(posedge clk);
        #2;

        send(0, 0, 5, 1, 1);    // closed bank (R2, R12)
        send(0, 0, 5, 2, 2);    // row hit (R3)
        send(1, 0, 5, 3, 3);    // write hit, no response (R9)
        send(0, 1, 9, 4, 4);    // other bank while bank 0 open (R11)
        send(0, 0, 7, 5, 5);    // row miss (R4)
        send(1, 0, 5, 6, 6);    // miss straight after activate (R4)
        send(0, 2, 1, 7, 7);
        send(0, 3, 1023, 63, 8); // address field extremes (R1)
        send(0, 3, 1023, 0, 9);
        idle(3);
        send(0, 1, 9, 10, 10);

        s = 32'h1357_9bdf;
        for (int k = 0; k < 60; k++) begin
            s = s * 32'd1103515245 + 32'd12345;
            send(s[16], int'(s[18:17]), int'(s[21:19]), int'(s[27:22]), k % 16);
            if (s[30]) idle(int'(s[29:28]) * 5);
        end

        idle(700);              // several refreshes while idle (R6, R7, R8)
        send(0, 1, 9, 11, 11);  // bank closed by refresh (R7)
        send(0, 1, 9, 12, 12);
        idle(40);

        chk(ref_count >= 3, "R6", "refresh count", ref_count, 3);
        chk(eq.size() == 0, "R10", "commands left unissued", eq.size(), 0);
        chk(rq.size() == 0, "R9", "responses left pending", rq.size(), 0);
        finish_run();
    end

endmodule